// File: doc/BRIEF.md
# Activation-Latched Supervision Timer

This block supervises software through one 8-bit register in data space. The register holds a 6-bit down-counter, a software-reset bit and an activation bit. Once the timer is armed, software must keep writing a fresh count into the register. If the count runs out, or if software deliberately clears the software-reset bit while the timer is armed, the block raises a chip reset request. That request is held for a fixed number of clocks and then released.

There are two ways to arm the timer. Software can write the activation bit, or an active-low hardware-select input can force it on. The activation bit is sticky: only a reset, or a reset request that the block raises itself, clears it.

While the timer is armed, a stop request from the core is passed on as a wait request. This keeps the clock alive, so the count keeps running through low-power periods.

Top module: `wdt_guard`

## Requirements
- R1: After synchronous reset the register reads 0xFE (counter all ones, software-reset bit 1, activation bit 0), and `rst_req`, `stop_out` and `wait_out` are 0.
- R2: Register layout: bits 7..2 are the counter, bit 1 is the software-reset bit and bit 0 is the activation bit. A write to address 0xD8 loads the counter and the software-reset bit. A write to any other address leaves the register unchanged.
- R3: Once the activation bit is 1, a write with bit 0 = 0 leaves it at 1.
- R4: While `hw_sel_n` is 0, the activation bit becomes 1 on the first clock edge after reset is released.
- R5: While armed, the counter decreases by one every 4 clocks (TICK_DIV), timed from the last register write or the end of a reset. While not armed, the counter does not change.
- R6: If the counter is loaded with N while armed and is not written again, `rst_req` rises exactly (N+1)*TICK_DIV clock edges after the write edge. This holds for every N from 0 to 63.
- R7: A write with bit 1 = 0 while the activation bit is already 1 raises `rst_req` on that write's edge. The same write while not armed only stores the value.
- R8: `rst_req` stays high for exactly 8 clocks (PULSE_LEN). During that time the register reads 0xFE and writes are ignored.
- R9: One clock after the request: while armed, a stop request gives `wait_out` = 1 and `stop_out` = 0. While not armed, stop passes through unchanged. A wait request always gives `wait_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data-space write strobe |
| wr_addr | input | 8 | Data-space write address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| hw_sel_n | input | 1 | Low forces the timer to be armed |
| stop_req | input | 1 | Stop request from the core |
| wait_req | input | 1 | Wait request from the core |
| stop_out | output | 1 | Stop request after filtering |
| wait_out | output | 1 | Wait request after filtering |
| rst_req | output | 1 | Chip reset request |

## Verification
Every result is due at a fixed clock edge:
- The register value and the low-power outputs change on the edge that samples their stimulus.
- A software reset request shows on the write edge itself.
- A timeout shows exactly (N+1)*4 edges after the write that loaded N.
- After a reset is released, a timeout shows 256 edges later.

The bench drives inputs on falling edges and samples on the next falling edge. It counts those half-period steps to the edge where each result is due. Timeouts are timed for every load value from 0 to 63, and each reset pulse is measured in clocks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Register contents after reset: counter all ones, software-reset bit set, not armed
  function automatic logic [7:0] rst_image(input int cnt_w);
    logic [7:0] v;
    v = '1;
    v[0] = 1'b0;
    return v;
  endfunction

  typedef struct packed {
    logic [5:0] cnt;
    logic       sr;
    logic       arm;
  } wdt_reg_t;
endpackage

// File: rtl/wdt_presc.sv
module wdt_presc #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clr)      pre <= '0;
    else if (pre == LAST) pre <= '0;
    else                 pre <= pre + PW'(1);
  end

  assign tick = (pre == LAST);

  // R5: ticks never come on two edges in a row
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> !tick);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic busy
);
  localparam int PCW = $clog2(PULSE_LEN + 1);

  logic [PCW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pcnt <= '0;
    end else if (busy) begin
      if (pcnt == '0) busy <= 1'b0;
      else            pcnt <= pcnt - PCW'(1);
    end else if (fire) begin
      busy <= 1'b1;
      pcnt <= PCW'(PULSE_LEN - 1);
    end
  end

  // Checker: measures the length of each high period of busy
  logic [PCW:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst)       hi_len <= '0;
    else if (busy) hi_len <= hi_len + (PCW+1)'(1);
    else           hi_len <= '0;
  end

  // R8: a reset request never lasts longer than PULSE_LEN clocks
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    hi_len <= (PCW+1)'(PULSE_LEN));

  // R8: a fire outside a pulse starts one
  fire_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !busy) |=> busy);
endmodule

// File: rtl/wdt_lowpwr.sv
module wdt_lowpwr (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic stop_req,
  input  logic wait_req,
  output logic stop_out,
  output logic wait_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stop_out <= 1'b0;
      wait_out <= 1'b0;
    end else begin
      stop_out <= stop_req & ~armed;
      wait_out <= wait_req | (stop_req & armed);
    end
  end

  // R9: while armed, a stop request becomes a wait
  stop_to_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_req && armed) |=> (wait_out && !stop_out));

  // R9: with no request, both outputs are low
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_req && !wait_req) |=> (!wait_out && !stop_out));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int          CNT_W    = 6,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'hD8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W+1:0]  wr_data,
  input  logic              hw_sel_n,
  input  logic              tick,
  input  logic              hold,
  output logic              fire,
  output logic              wr_hit,
  output logic              armed,
  output logic [CNT_W+1:0]  rd_data
);
  localparam int REG_W = CNT_W + 2;
  localparam logic [REG_W-1:0] RST_VAL = {{CNT_W{1'b1}}, 1'b1, 1'b0};

  logic [CNT_W-1:0] cnt;
  logic             sr;
  logic             arm;
  logic             tmo;
  logic             swr;

  assign wr_hit = wr_en && (wr_addr == ADDR_W'(REG_ADDR)) && !hold;
  assign tmo    = arm && tick && (cnt == '0) && !hold && !wr_hit;
  assign swr    = wr_hit && arm && !wr_data[1];
  assign fire   = tmo | swr;

  always_ff @(posedge clk) begin
    if (rst || hold || fire) begin
      cnt <= '1;
      sr  <= 1'b1;
      arm <= 1'b0;
    end else if (wr_hit) begin
      cnt <= wr_data[REG_W-1:2];
      sr  <= wr_data[1];
      arm <= arm | wr_data[0] | ~hw_sel_n;
    end else begin
      if (tick && arm) cnt <= cnt - CNT_W'(1);
      if (!hw_sel_n)   arm <= 1'b1;
    end
  end

  assign armed   = arm;
  assign rd_data = {cnt, sr, arm};

  // R3: the activation bit only falls through reset or a reset request
  arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && !hold && !fire) |=> arm);

  // R8: during a reset request the register shows its reset image
  hold_image_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (rd_data == RST_VAL));

  // R5: the counter is steady between ticks and writes
  cnt_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_hit && !hold && !fire) |=> $stable(cnt));

  // R2: a write lands in the register on its own edge
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !fire) |=> (cnt == $past(wr_data[REG_W-1:2])));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int         CNT_W     = 6,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] REG_ADDR  = 8'hD8,
  parameter int         TICK_DIV  = 4,
  parameter int         PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W+1:0]  wr_data,
  output logic [CNT_W+1:0]  rd_data,
  input  logic              hw_sel_n,
  input  logic              stop_req,
  input  logic              wait_req,
  output logic              stop_out,
  output logic              wait_out,
  output logic              rst_req
);
  logic tick, fire, wr_hit, armed, presc_clr;

  assign presc_clr = wr_hit | fire | rst_req;

  wdt_presc #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst(rst), .clr(presc_clr), .tick(tick)
  );

  wdt_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_sel_n(hw_sel_n), .tick(tick), .hold(rst_req), .fire(fire),
    .wr_hit(wr_hit), .armed(armed), .rd_data(rd_data)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .busy(rst_req)
  );

  wdt_lowpwr u_lp (
    .clk(clk), .rst(rst), .armed(armed), .stop_req(stop_req),
    .wait_req(wait_req), .stop_out(stop_out), .wait_out(wait_out)
  );

  // R7: a software reset request appears on the write edge
  sw_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && armed && !wr_data[1]) |=> rst_req);
endmodule

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       hw_sel_n = 1'b1;
  logic       stop_req = 1'b0;
  logic       wait_req = 1'b0;
  logic       stop_out, wait_out, rst_req;

  int checks = 0;
  int errors = 0;

  localparam int DIV = 4;
  localparam int PL  = 8;

  always #5 clk = ~clk;

  wdt_guard u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .hw_sel_n(hw_sel_n), .stop_req(stop_req),
    .wait_req(wait_req), .stop_out(stop_out), .wait_out(wait_out),
    .rst_req(rst_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!rst_req && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (rst_req && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset image", rd_data, 8'hFE);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 low-power outputs", {stop_out, wait_out}, 0);
    rst = 1'b0;

    // R2: write to another address ignored
    wr(8'hD9, 8'h00);
    chk("R2 other address", rd_data, 8'hFE);

    // R7 / R5: SR=0 while not armed just stored, counter frozen
    wr(8'hD8, 8'h14);
    chk("R7 store unarmed", rd_data, 8'h14);
    chk("R7 no request unarmed", rst_req, 0);
    repeat (20) @(negedge clk);
    chk("R5 frozen unarmed", rd_data, 8'h14);

    // R9: not armed, stop passes
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk);
    chk("R9 stop passes", {stop_out, wait_out}, 2);
    stop_req = 1'b0;

    // R2 / R5: arm with count 10, then two ticks later it reads 8
    wr(8'hD8, 8'h2B);
    chk("R2 loaded", rd_data, 8'h2B);
    repeat (2 * DIV) @(negedge clk);
    chk("R5 decrement", rd_data >> 2, 8);

    // R3: writing arm=0 does not disarm
    wr(8'hD8, 8'h2A);
    chk("R3 sticky arm", rd_data, 8'h2B);

    // R9: armed stop becomes wait; wait passes
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk);
    chk("R9 stop to wait", {stop_out, wait_out}, 1);
    stop_req = 1'b0; wait_req = 1'b1;
    @(negedge clk);
    chk("R9 wait passes", {stop_out, wait_out}, 1);
    wait_req = 1'b0;

    // R7: SR=0 while armed fires at once
    wr(8'hD8, 8'h29);
    chk("R7 software reset", rst_req, 1);
    // R8: a write during the pulse is ignored
    wr(8'hD8, 8'h55);
    chk("R8 write ignored", rd_data, 8'hFE);
    chk("R8 still held", rst_req, 1);
    pulse_len(n);
    chk("R8 pulse rest", n, PL - 2);
    chk("R8 image after", rd_data, 8'hFE);

    // R6 / R8: sweep every load value
    for (int v = 0; v < 64; v++) begin
      wr(8'hD8, 8'((v << 2) | 3));
      wait_rise(n);
      chk($sformatf("R6 timeout N=%0d", v), n, (v + 1) * DIV);
      pulse_len(n);
      chk($sformatf("R8 pulse N=%0d", v), n, PL);
      chk($sformatf("R8 image N=%0d", v), rd_data, 8'hFE);
    end

    // R4: hardware-select arms after reset
    @(negedge clk); rst = 1'b1; hw_sel_n = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 armed by pin", rd_data, 8'hFF);
    wait_rise(n);
    chk("R4 timeout after reset", n + 1, 64 * DIV);
    pulse_len(n);
    chk("R4 pulse", n, PL);
    wait_rise(n);
    chk("R4 rearmed timeout", n, 64 * DIV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule